// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block is the register front end of a serial port peripheral that sits on an APB-style slave bus. It decodes five word-aligned registers. These are a data port, a baud divisor, a line control word, an interrupt enable mask and a live interrupt status. A write to the data port becomes a single-cycle push strobe toward an external transmit FIFO. A read of the data port returns the head of an external receive FIFO and gives a single-cycle pop strobe. Both FIFOs and the serial engine live outside this block. They are seen only through their data, full/empty flags and occupancy counts.

The line control word holds the frame options: stop-bit count, parity enable and parity type. It also holds one watermark per FIFO. The status register is not a set of latches. Each bit follows its condition directly: FIFO full, FIFO empty, transmit occupancy below its watermark, and receive occupancy above its watermark. A single interrupt line is raised whenever any status bit is set and its enable bit is set too. The divisor, control and enable registers come out of reset with parameter-chosen values. All state is reset synchronously by an active-low reset.

Top module: `apb_uart_regs`

## Requirements
- R1: After reset, the divisor reads back RST_DIV (default 434), the control word reads back RST_CTRL (default 0x08080: both watermarks 16, one stop bit, parity off) and the enable mask reads back RST_IEN (default 0).
- R2: A write access to offset 0x04 loads the divisor from wdata[DIV_W-1:0]. Offset 0x08 loads the control word from wdata[18:0], and offset 0x0C loads the enable mask from wdata[5:0]. Reads return these bits with zeros above them. Control bit 0 drives stop_two_o (1 = two stop bits), bit 1 drives par_en_o and bit 2 drives par_even_o (1 = even, 0 = odd). No other access changes these registers.
- R3: A write access to offset 0x00 while tx_full_i is low raises tx_push_o for exactly that access cycle, with tx_data_o equal to wdata[7:0]. tx_push_o is low at all other times.
- R4: A write access to offset 0x00 while tx_full_i is high is dropped. tx_push_o stays low and pslverr_o stays low.
- R5: A read access to offset 0x00 while rx_empty_i is low returns rx_data_i in prdata_o[7:0] with zeros above. It raises rx_pop_o for exactly that access cycle, and pslverr_o stays low.
- R6: A read access to offset 0x00 while rx_empty_i is high returns 0, raises pslverr_o and leaves rx_pop_o low.
- R7: Offset 0x10 reads the live status. Bit 0 is tx_full_i, bit 1 rx_full_i, bit 2 tx_empty_i and bit 3 rx_empty_i. Bits 4 and 5 are the watermark conditions of R8, and bits 31:6 read 0.
- R8: Status bit 4 is set when tx_count_i is strictly less than control bits [10:3]. Status bit 5 is set when rx_count_i is strictly greater than control bits [18:11].
- R9: irq_o is high exactly when some status bit and the enable bit at the same position are both set. It follows input changes in the same cycle.
- R10: A write to offset 0x10, or any access to an offset above 0x10, raises pslverr_o and changes no register. A read of an offset above 0x10 returns 0.
- R11: pready_o is always high, so every access completes in one access cycle. pslverr_o is high only during an access phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access phase marker |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | ADDR_W | Byte address; bits [ADDR_W-1:2] pick the register |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, zero outside a read access |
| pready_o | output | 1 | Transfer ready, tied high |
| pslverr_o | output | 1 | Transfer error |
| tx_push_o | output | 1 | Transmit FIFO push strobe |
| tx_data_o | output | 8 | Byte to push |
| tx_full_i | input | 1 | Transmit FIFO full |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_count_i | input | CNT_W | Transmit FIFO occupancy |
| rx_pop_o | output | 1 | Receive FIFO pop strobe |
| rx_data_i | input | 8 | Receive FIFO head byte |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_empty_i | input | 1 | Receive FIFO empty |
| rx_count_i | input | CNT_W | Receive FIFO occupancy |
| baud_div_o | output | DIV_W | Clock-to-baud divisor |
| stop_two_o | output | 1 | Two stop bits selected |
| par_en_o | output | 1 | Parity enabled |
| par_even_o | output | 1 | Even parity selected |
| irq_o | output | 1 | Combined interrupt |

## Verification
Data-port accesses are tried with the transmit FIFO both full and not full, and with the receive FIFO both empty and not empty. This separates a push from a drop and a pop from an error. The occupancy counts are placed one below, at, and one above each watermark, which pins down the strict inequalities in both directions. The enable mask is swept with a single status source active, so an AND/OR mix-up shows in irq_o. Writes to the status offset and to unmapped offsets are followed by read-back of every register, which shows that no state was touched.

// File: rtl/apb_uart_pkg.sv
package apb_uart_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned WM_W   = 8;
  localparam int unsigned CTRL_W = 3 + 2 * WM_W;
  localparam int unsigned NSRC   = 6;

  // status / enable bit positions
  localparam int unsigned S_TX_FULL  = 0;
  localparam int unsigned S_RX_FULL  = 1;
  localparam int unsigned S_TX_EMPTY = 2;
  localparam int unsigned S_RX_EMPTY = 3;
  localparam int unsigned S_TX_LOW   = 4;
  localparam int unsigned S_RX_HIGH  = 5;

  typedef enum logic [2:0] {
    REG_DATA = 3'd0,
    REG_DIV  = 3'd1,
    REG_CTRL = 3'd2,
    REG_IEN  = 3'd3,
    REG_STAT = 3'd4,
    REG_NONE = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic [WM_W-1:0] rx_wm;
    logic [WM_W-1:0] tx_wm;
    logic            par_even;
    logic            par_en;
    logic            stop_two;
  } ctrl_t;
endpackage

// File: rtl/apb_uart_decode.sv
module apb_uart_decode import apb_uart_pkg::*; #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  output reg_sel_e          sel_o,
  output logic              wr_o,
  output logic              rd_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             access;
  logic             unused_addr;

  assign idx         = paddr_i[ADDR_W-1:2];
  assign access      = psel_i & penable_i;
  assign wr_o        = access & pwrite_i;
  assign rd_o        = access & ~pwrite_i;
  assign unused_addr = ^paddr_i[1:0];

  always_comb begin
    if      (idx == IDX_W'(0)) sel_o = REG_DATA;
    else if (idx == IDX_W'(1)) sel_o = REG_DIV;
    else if (idx == IDX_W'(2)) sel_o = REG_CTRL;
    else if (idx == IDX_W'(3)) sel_o = REG_IEN;
    else if (idx == IDX_W'(4)) sel_o = REG_STAT;
    else                       sel_o = REG_NONE;
  end
endmodule

// File: rtl/apb_uart_csr.sv
module apb_uart_csr import apb_uart_pkg::*; #(
  parameter int unsigned DIV_W = 16,
  parameter logic [DIV_W-1:0]  RST_DIV  = DIV_W'(434),
  parameter logic [CTRL_W-1:0] RST_CTRL = CTRL_W'('h08080),
  parameter logic [NSRC-1:0]   RST_IEN  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DIV_W-1:0]  div_o,
  output ctrl_t             ctrl_o,
  output logic [NSRC-1:0]   ien_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      div_o  <= RST_DIV;
      ctrl_o <= ctrl_t'(RST_CTRL);
      ien_o  <= RST_IEN;
    end else if (wr_i) begin
      case (sel_i)
        REG_DIV:  div_o  <= wdata_i[DIV_W-1:0];
        REG_CTRL: ctrl_o <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        REG_IEN:  ien_o  <= wdata_i[NSRC-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/apb_uart_irq.sv
module apb_uart_irq import apb_uart_pkg::*; #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             tx_full_i,
  input  logic             tx_empty_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic             rx_full_i,
  input  logic             rx_empty_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [WM_W-1:0]  tx_wm_i,
  input  logic [WM_W-1:0]  rx_wm_i,
  input  logic [NSRC-1:0]  ien_i,
  output logic [NSRC-1:0]  stat_o,
  output logic             irq_o
);
  localparam int unsigned CMP_W = (CNT_W > WM_W) ? CNT_W : WM_W;

  logic [CMP_W-1:0] tx_cnt_x, rx_cnt_x, tx_wm_x, rx_wm_x;
  logic [NSRC-1:0]  hit;

  assign tx_cnt_x = CMP_W'(tx_count_i);
  assign rx_cnt_x = CMP_W'(rx_count_i);
  assign tx_wm_x  = CMP_W'(tx_wm_i);
  assign rx_wm_x  = CMP_W'(rx_wm_i);

  always_comb begin
    stat_o             = '0;
    stat_o[S_TX_FULL]  = tx_full_i;
    stat_o[S_RX_FULL]  = rx_full_i;
    stat_o[S_TX_EMPTY] = tx_empty_i;
    stat_o[S_RX_EMPTY] = rx_empty_i;
    stat_o[S_TX_LOW]   = tx_cnt_x < tx_wm_x;
    stat_o[S_RX_HIGH]  = rx_cnt_x > rx_wm_x;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_mask
    assign hit[g] = stat_o[g] & ien_i[g];
  end

  assign irq_o = |hit;
endmodule

// File: rtl/apb_uart_regs.sv
module apb_uart_regs import apb_uart_pkg::*; #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned CNT_W  = 11,
  parameter logic [DIV_W-1:0]  RST_DIV  = DIV_W'(434),
  parameter logic [CTRL_W-1:0] RST_CTRL = CTRL_W'('h08080),
  parameter logic [NSRC-1:0]   RST_IEN  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  output logic              tx_push_o,
  output logic [7:0]        tx_data_o,
  input  logic              tx_full_i,
  input  logic              tx_empty_i,
  input  logic [CNT_W-1:0]  tx_count_i,
  output logic              rx_pop_o,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_full_i,
  input  logic              rx_empty_i,
  input  logic [CNT_W-1:0]  rx_count_i,
  output logic [DIV_W-1:0]  baud_div_o,
  output logic              stop_two_o,
  output logic              par_en_o,
  output logic              par_even_o,
  output logic              irq_o
);
  reg_sel_e          sel;
  logic              wr, rd;
  logic [DIV_W-1:0]  div_q;
  ctrl_t             ctrl_q;
  logic [NSRC-1:0]   ien_q;
  logic [NSRC-1:0]   stat;
  logic [DATA_W-1:0] rdata;

  apb_uart_decode #(.ADDR_W(ADDR_W)) u_dec (
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .pwrite_i  (pwrite_i),
    .paddr_i   (paddr_i),
    .sel_o     (sel),
    .wr_o      (wr),
    .rd_o      (rd)
  );

  apb_uart_csr #(
    .DIV_W(DIV_W), .RST_DIV(RST_DIV), .RST_CTRL(RST_CTRL), .RST_IEN(RST_IEN)
  ) u_csr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .sel_i   (sel),
    .wdata_i (pwdata_i),
    .div_o   (div_q),
    .ctrl_o  (ctrl_q),
    .ien_o   (ien_q)
  );

  apb_uart_irq #(.CNT_W(CNT_W)) u_irq (
    .tx_full_i  (tx_full_i),
    .tx_empty_i (tx_empty_i),
    .tx_count_i (tx_count_i),
    .rx_full_i  (rx_full_i),
    .rx_empty_i (rx_empty_i),
    .rx_count_i (rx_count_i),
    .tx_wm_i    (ctrl_q.tx_wm),
    .rx_wm_i    (ctrl_q.rx_wm),
    .ien_i      (ien_q),
    .stat_o     (stat),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (sel)
        REG_DATA: if (!rx_empty_i) rdata = DATA_W'(rx_data_i);
        REG_DIV:  rdata = DATA_W'(div_q);
        REG_CTRL: rdata = DATA_W'(ctrl_q);
        REG_IEN:  rdata = DATA_W'(ien_q);
        REG_STAT: rdata = DATA_W'(stat);
        default:  rdata = '0;
      endcase
    end
  end

  assign prdata_o  = rdata;
  assign pready_o  = 1'b1;
  assign pslverr_o = (wr & ((sel == REG_STAT) | (sel == REG_NONE)))
                   | (rd & ((sel == REG_NONE) | ((sel == REG_DATA) & rx_empty_i)));

  assign tx_push_o = wr & (sel == REG_DATA) & ~tx_full_i;
  assign tx_data_o = pwdata_i[7:0];
  assign rx_pop_o  = rd & (sel == REG_DATA) & ~rx_empty_i;

  assign baud_div_o = div_q;
  assign stop_two_o = ctrl_q.stop_two;
  assign par_en_o   = ctrl_q.par_en;
  assign par_even_o = ctrl_q.par_even;
endmodule

// File: rtl/apb_uart_regs_chk.sv
module apb_uart_regs_chk import apb_uart_pkg::*; #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DIV_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              psel_i,
  input logic              penable_i,
  input logic              pwrite_i,
  input logic [ADDR_W-1:0] paddr_i,
  input logic              pslverr_o,
  input logic              tx_push_o,
  input logic              tx_full_i,
  input logic              rx_pop_o,
  input logic              rx_empty_i,
  input logic              irq_o,
  input logic [DIV_W-1:0]  div_q,
  input logic [NSRC-1:0]   ien_q
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             acc;
  assign idx = paddr_i[ADDR_W-1:2];
  assign acc = psel_i && penable_i;

  p_push_access_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |-> (acc && pwrite_i && idx == IDX_W'(0)));

  p_drop_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full_i |-> !tx_push_o);

  p_pop_access_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> (acc && !pwrite_i && idx == IDX_W'(0) && !rx_empty_i));

  p_empty_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !pwrite_i && idx == IDX_W'(0) && rx_empty_i) |-> (pslverr_o && !rx_pop_o));

  p_stat_ro_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && pwrite_i && idx >= IDX_W'(4)) |-> pslverr_o);

  p_div_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc && pwrite_i && idx == IDX_W'(1)) |=> $stable(div_q));

  p_irq_masked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ien_q != '0));

  p_err_access_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pslverr_o |-> acc);
endmodule

bind apb_uart_regs apb_uart_regs_chk #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/apb_uart_regs_test.sv
module apb_uart_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = 0;
  logic [31:0] pwdata = 0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        tx_push;
  logic [7:0]  tx_data;
  logic        tx_full = 0, tx_empty = 1;
  logic [10:0] tx_count = 0;
  logic        rx_pop;
  logic [7:0]  rx_data = 0;
  logic        rx_full = 0, rx_empty = 1;
  logic [10:0] rx_count = 0;
  logic [15:0] baud_div;
  logic        stop_two, par_en, par_even, irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit seen_rst = 0;
  bit done = 0;

  always #10 clk = ~clk;

  apb_uart_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready),
    .pslverr_o(pslverr), .tx_push_o(tx_push), .tx_data_o(tx_data), .tx_full_i(tx_full),
    .tx_empty_i(tx_empty), .tx_count_i(tx_count), .rx_pop_o(rx_pop), .rx_data_i(rx_data),
    .rx_full_i(rx_full), .rx_empty_i(rx_empty), .rx_count_i(rx_count),
    .baud_div_o(baud_div), .stop_two_o(stop_two), .par_en_o(par_en),
    .par_even_o(par_even), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference register state
  int m_div, m_ctrl, m_ien;
  byte unsigned txq[$];
  byte unsigned tx_seen[$];

  function automatic int stat_model();
    int s = 0;
    if (tx_full)  s |= 1;
    if (rx_full)  s |= 2;
    if (tx_empty) s |= 4;
    if (rx_empty) s |= 8;
    if (int'(tx_count) < ((m_ctrl >> 3) & 255))  s |= 16;
    if (int'(rx_count) > ((m_ctrl >> 11) & 255)) s |= 32;
    return s;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      seen_rst = 1;
      m_div = 434; m_ctrl = 'h08080; m_ien = 0;
    end else begin
      if (tx_push) tx_seen.push_back(tx_data);
      if (psel && penable && pwrite) begin
        case (paddr)
          8'h04: m_div  = int'(pwdata & 32'hFFFF);
          8'h08: m_ctrl = int'(pwdata & 32'h7FFFF);
          8'h0C: m_ien  = int'(pwdata & 32'h3F);
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (seen_rst && rst_n && !done) begin
      int idx;
      bit acc, e_push, e_pop, e_err;
      int e_rd;
      idx = int'(paddr >> 2);
      acc = psel && penable;
      e_push = acc && pwrite && idx == 0 && !tx_full;
      e_pop  = acc && !pwrite && idx == 0 && !rx_empty;
      e_err  = acc && ((pwrite && idx == 4) || idx > 4 || (!pwrite && idx == 0 && rx_empty));
      chk("R3 push", {31'b0, tx_push}, {31'b0, e_push});
      chk("R5 pop", {31'b0, rx_pop}, {31'b0, e_pop});
      chk("R10 pslverr", {31'b0, pslverr}, {31'b0, e_err});
      chk("R9 irq", {31'b0, irq}, {31'b0, (stat_model() & m_ien) != 0});
      chk("R2 divisor out", {16'b0, baud_div}, m_div);
      chk("R2 frame bits", {29'b0, par_even, par_en, stop_two}, m_ctrl & 7);
      if (acc && !pwrite) begin
        case (idx)
          0: e_rd = rx_empty ? 0 : int'(rx_data);
          1: e_rd = m_div;
          2: e_rd = m_ctrl;
          3: e_rd = m_ien;
          4: e_rd = stat_model();
          default: e_rd = 0;
        endcase
        chk("R7 prdata", prdata, e_rd);
      end
      if (e_push) chk("R3 tx_data", {24'b0, tx_data}, {24'b0, pwdata[7:0]});
    end
  end

  logic [31:0] r_data;
  logic        r_err, r_strobe;

  task automatic apb(input logic wr, input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    @(posedge clk); #1;
    penable = 1;
    @(negedge clk);
    r_data = prdata; r_err = pslverr;
    r_strobe = wr ? tx_push : rx_pop;
    chk("R11 pready", {31'b0, pready}, 32'd1);
    @(posedge clk); #1;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic settle();
    @(posedge clk); #1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset values
    apb(0, 8'h04, 0); chk("R1 divisor", r_data, 434);
    apb(0, 8'h08, 0); chk("R1 control", r_data, 'h08080);
    apb(0, 8'h0C, 0); chk("R1 enable", r_data, 0);
    chk("R1 frame bits", {29'b0, par_even, par_en, stop_two}, 0);

    // R2 register writes
    apb(1, 8'h04, 32'h1234_0ABC); apb(0, 8'h04, 0); chk("R2 divisor", r_data, 32'h0ABC);
    apb(1, 8'h08, 32'hFFFF_FFFF); apb(0, 8'h08, 0); chk("R2 control all", r_data, 32'h7FFFF);
    chk("R2 frame bits set", {29'b0, par_even, par_en, stop_two}, 7);
    apb(1, 8'h08, 32'h1829); apb(0, 8'h08, 0); chk("R2 control", r_data, 32'h1829);
    chk("R2 stop only", {29'b0, par_even, par_en, stop_two}, 1);

    // R7 / R8 live status, tx wm 5, rx wm 3
    tx_full = 1; tx_empty = 0; rx_empty = 1; tx_count = 4; rx_count = 0;
    apb(0, 8'h10, 0); chk("R7 status", r_data, 32'h19);
    tx_count = 5; rx_count = 3;
    apb(0, 8'h10, 0); chk("R8 at watermarks", r_data, 32'h09);
    rx_count = 4;
    apb(0, 8'h10, 0); chk("R8 rx above", r_data, 32'h29);
    tx_count = 4;
    apb(0, 8'h10, 0); chk("R8 tx below", r_data, 32'h39);
    rx_full = 1; rx_empty = 0; tx_full = 0; tx_empty = 1;
    apb(0, 8'h10, 0); chk("R7 swapped flags", r_data, 32'h36);

    // R4 drop when full
    tx_full = 1;
    apb(1, 8'h00, 32'h55);
    chk("R4 no push", {31'b0, r_strobe}, 0);
    chk("R4 no error", {31'b0, r_err}, 0);

    // R3 pushes
    tx_full = 0;
    apb(1, 8'h00, 32'hA5); chk("R3 push", {31'b0, r_strobe}, 1); txq.push_back(8'hA5);
    apb(1, 8'h00, 32'h1C3); txq.push_back(8'hC3);

    // R5 read with data
    rx_data = 8'h7E;
    apb(0, 8'h00, 0);
    chk("R5 data", r_data, 32'h7E);
    chk("R5 pop", {31'b0, r_strobe}, 1);
    chk("R5 no error", {31'b0, r_err}, 0);

    // R6 read when empty
    rx_empty = 1;
    apb(0, 8'h00, 0);
    chk("R6 data", r_data, 0);
    chk("R6 error", {31'b0, r_err}, 1);
    chk("R6 no pop", {31'b0, r_strobe}, 0);

    // R9 interrupt masking
    tx_full = 0; tx_empty = 0; rx_full = 0; rx_empty = 0; tx_count = 5; rx_count = 0;
    apb(1, 8'h0C, 32'h3F); settle(); chk("R9 no source", {31'b0, irq}, 0);
    tx_empty = 1; settle(); chk("R9 tx empty on", {31'b0, irq}, 1);
    apb(1, 8'h0C, 32'h3B); settle(); chk("R9 masked", {31'b0, irq}, 0);
    apb(1, 8'h0C, 32'h04); settle(); chk("R9 single enable", {31'b0, irq}, 1);
    tx_empty = 0; settle(); chk("R9 source gone", {31'b0, irq}, 0);

    // R10 status write and unmapped
    apb(1, 8'h10, 32'hFF); chk("R10 status write err", {31'b0, r_err}, 1);
    apb(1, 8'h14, 32'h1);  chk("R10 unmapped write err", {31'b0, r_err}, 1);
    apb(1, 8'hFC, 32'h1);  chk("R10 far write err", {31'b0, r_err}, 1);
    apb(0, 8'h14, 0); chk("R10 unmapped read", r_data, 0); chk("R10 read err", {31'b0, r_err}, 1);
    apb(0, 8'h0C, 0); chk("R10 enable kept", r_data, 32'h04);
    apb(0, 8'h04, 0); chk("R10 divisor kept", r_data, 32'h0ABC);
    apb(0, 8'h08, 0); chk("R10 control kept", r_data, 32'h1829);

    // R11 idle
    settle(); chk("R11 idle no error", {31'b0, pslverr}, 0);
    chk("R11 idle ready", {31'b0, pready}, 1);

    // R3 captured pushes
    chk("R3 push count", tx_seen.size(), txq.size());
    foreach (txq[i]) if (i < tx_seen.size()) chk("R3 pushed byte", {24'b0, tx_seen[i]}, {24'b0, txq[i]});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles >= 100000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule